// File: doc/BRIEF.md
# Static Not-Taken Branch Redirect and Squash Unit

This unit is the control-hazard logic for a five-stage in-order pipeline that assumes every branch falls through. It owns the fetch address register. It steps that address by a fixed increment each cycle, so fetch keeps running sequentially past any branch. It also keeps the valid flags of the fetch/decode and decode/execute pipeline registers.

Branches resolve at the end of execute. When the execute stage reports a taken branch, the unit does three things:
- It loads the branch target as the next fetch address.
- It raises squash signals for both younger pipeline registers, so the two wrongly fetched instructions become bubbles. A taken branch therefore costs exactly two slots.
- It bumps a saturating count of taken branches. A bench or a performance monitor can relate that count to cycles per instruction.

A branch that stays not-taken costs nothing. A stall request freezes fetch and sends a bubble into execute. A redirect in the same cycle overrides the stall.

Top module: `bfc_flush_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is a fetch address of zero, both valid flags low and a taken count of zero.
- R2: With no stall and no accepted redirect, the fetch address grows by STEP (default 4, wrapping modulo 2^AW) at each edge. The fetch/decode flag then becomes 1 and the decode/execute flag takes the old fetch/decode flag.
- R3: A redirect is accepted when `ex_br_valid_i`, `ex_br_taken_i` and `idex_valid_o` are all high. In that cycle, `pc_next_o` equals `ex_br_target_i`, and both `flush_ifid_o` and `flush_idex_o` are high. After the edge, `fetch_pc_o` holds the target.
- R4: After an accepted redirect, both `ifid_valid_o` and `idex_valid_o` are 0 at the next edge, which squashes two slots.
- R5: A valid branch that resolves not-taken raises no squash signal. Fetch then advances as in R2, with no lost cycle.
- R6: With `stall_i` high and no accepted redirect, `fetch_pc_o` and `ifid_valid_o` hold, `idex_valid_o` becomes 0, and `pc_next_o` equals `fetch_pc_o`.
- R7: When a redirect is accepted in the same cycle as `stall_i`, the redirect wins. The fetch address becomes the target and both flags clear.
- R8: Branch indications arriving while `idex_valid_o` is 0 are ignored. No squash is raised, the fetch address steps normally and the count is unchanged.
- R9: `miss_count_o` grows by one for each accepted redirect and saturates at 2^CNT_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_i | input | 1 | Stall request from the hazard unit |
| ex_br_valid_i | input | 1 | Execute stage holds a branch |
| ex_br_taken_i | input | 1 | That branch resolved taken |
| ex_br_target_i | input | AW | Resolved branch target address |
| fetch_pc_o | output | AW | Current fetch address (registered) |
| pc_next_o | output | AW | Address loaded at the next edge |
| flush_ifid_o | output | 1 | Squash the fetch/decode register |
| flush_idex_o | output | 1 | Squash the decode/execute register |
| ifid_valid_o | output | 1 | Fetch/decode register holds a live instruction |
| idex_valid_o | output | 1 | Decode/execute register holds a live instruction |
| miss_count_o | output | CNT_W | Saturating count of taken branches |

## Verification
The squash signals and `pc_next_o` are combinational in the same cycle as the execute-stage inputs. The fetch address, both valid flags and the count change one edge after the stimulus.

The bench drives each cycle's inputs on the falling edge. A reference model then queues one expected item for that cycle. The monitor reads the same-cycle outputs 1 ns after that falling edge, and reads the registered outputs 1 ns after the following rising edge. Every comparison therefore lands in the cycle the requirement names.

A stretch of back-to-back redirects shows the two-slot refill, and a branch on a bubble shows the R8 gating.

// File: rtl/bfc_pkg.sv
package bfc_pkg;

  typedef enum logic [1:0] {
    PCSEL_SEQ      = 2'd0,
    PCSEL_HOLD     = 2'd1,
    PCSEL_REDIRECT = 2'd2
  } pc_sel_e;

endpackage

// File: rtl/bfc_resolve.sv
module bfc_resolve
  import bfc_pkg::*;
(
  input  logic    br_valid,
  input  logic    br_taken,
  input  logic    ex_live,
  input  logic    stall,
  output logic    redirect,
  output pc_sel_e pc_sel
);

  always_comb begin
    redirect = br_valid & br_taken & ex_live;
    if (redirect)
      pc_sel = PCSEL_REDIRECT;
    else if (stall)
      pc_sel = PCSEL_HOLD;
    else
      pc_sel = PCSEL_SEQ;
  end

endmodule

// File: rtl/bfc_pc_gen.sv
module bfc_pc_gen
  import bfc_pkg::*;
#(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  pc_sel_e       pc_sel,
  input  logic [AW-1:0] target,
  output logic [AW-1:0] pc_q,
  output logic [AW-1:0] pc_next
);

  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  always_comb begin
    unique case (pc_sel)
      PCSEL_REDIRECT: pc_next = target;
      PCSEL_HOLD:     pc_next = pc_q;
      default:        pc_next = pc_q + STEP_V;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      pc_q <= '0;
    else
      pc_q <= pc_next;
  end

endmodule

// File: rtl/bfc_valid_track.sv
module bfc_valid_track (
  input  logic clk,
  input  logic rst,
  input  logic redirect,
  input  logic stall,
  output logic ifid_v,
  output logic idex_v
);

  always_ff @(posedge clk) begin
    if (rst || redirect) begin
      ifid_v <= 1'b0;
      idex_v <= 1'b0;
    end else if (stall) begin
      idex_v <= 1'b0;
    end else begin
      ifid_v <= 1'b1;
      idex_v <= ifid_v;
    end
  end

endmodule

// File: rtl/bfc_miss_count.sv
module bfc_miss_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)
      count <= '0;
    else if (inc && count != CNT_MAX)
      count <= count + 1'b1;
  end

endmodule

// File: rtl/bfc_flush_ctrl.sv
module bfc_flush_ctrl
  import bfc_pkg::*;
#(
  parameter int AW    = 32,
  parameter int STEP  = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stall_i,
  input  logic             ex_br_valid_i,
  input  logic             ex_br_taken_i,
  input  logic [AW-1:0]    ex_br_target_i,
  output logic [AW-1:0]    fetch_pc_o,
  output logic [AW-1:0]    pc_next_o,
  output logic             flush_ifid_o,
  output logic             flush_idex_o,
  output logic             ifid_valid_o,
  output logic             idex_valid_o,
  output logic [CNT_W-1:0] miss_count_o
);

  logic    redirect;
  pc_sel_e pc_sel;

  bfc_resolve u_resolve (
    .br_valid (ex_br_valid_i),
    .br_taken (ex_br_taken_i),
    .ex_live  (idex_valid_o),
    .stall    (stall_i),
    .redirect (redirect),
    .pc_sel   (pc_sel)
  );

  bfc_pc_gen #(.AW(AW), .STEP(STEP)) u_pc (
    .clk     (clk),
    .rst     (rst),
    .pc_sel  (pc_sel),
    .target  (ex_br_target_i),
    .pc_q    (fetch_pc_o),
    .pc_next (pc_next_o)
  );

  bfc_valid_track u_valid (
    .clk      (clk),
    .rst      (rst),
    .redirect (redirect),
    .stall    (stall_i),
    .ifid_v   (ifid_valid_o),
    .idex_v   (idex_valid_o)
  );

  bfc_miss_count #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .inc   (redirect),
    .count (miss_count_o)
  );

  assign flush_ifid_o = redirect;
  assign flush_idex_o = redirect;

endmodule

// File: rtl/bfc_flush_ctrl_chk.sv
module bfc_flush_ctrl_chk #(
  parameter int AW    = 32,
  parameter int STEP  = 4,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             stall_i,
  input logic             ex_br_valid_i,
  input logic             ex_br_taken_i,
  input logic [AW-1:0]    ex_br_target_i,
  input logic [AW-1:0]    fetch_pc_o,
  input logic [AW-1:0]    pc_next_o,
  input logic             flush_ifid_o,
  input logic             flush_idex_o,
  input logic             ifid_valid_o,
  input logic             idex_valid_o,
  input logic [CNT_W-1:0] miss_count_o
);

  localparam logic [AW-1:0]    STEP_V = AW'(STEP);
  localparam logic [CNT_W-1:0] CMAX   = {CNT_W{1'b1}};

  logic take;
  assign take = ex_br_valid_i & ex_br_taken_i & idex_valid_o;

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (fetch_pc_o == '0 && !ifid_valid_o && !idex_valid_o && miss_count_o == '0));

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall_i && !take) |=> (fetch_pc_o == $past(fetch_pc_o) + STEP_V && ifid_valid_o));

  // R3
  redirect_pc_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> fetch_pc_o == $past(ex_br_target_i));

  // R3
  redirect_flush_chk: assert property (@(posedge clk) disable iff (rst)
    take |-> (flush_ifid_o && flush_idex_o && pc_next_o == ex_br_target_i));

  // R4
  two_bubble_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> (!ifid_valid_o && !idex_valid_o));

  // R5
  not_taken_free_chk: assert property (@(posedge clk) disable iff (rst)
    (ex_br_valid_i && !ex_br_taken_i) |-> (!flush_ifid_o && !flush_idex_o));

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (stall_i && !take) |=> (fetch_pc_o == $past(fetch_pc_o) &&
                            ifid_valid_o == $past(ifid_valid_o) && !idex_valid_o));

  // R7
  flush_beats_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (stall_i && take) |=> (fetch_pc_o == $past(ex_br_target_i) && !ifid_valid_o));

  // R8
  bubble_branch_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (ex_br_valid_i && ex_br_taken_i && !idex_valid_o) |-> (!flush_ifid_o && !flush_idex_o));

  // R9
  count_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (take && miss_count_o != CMAX) |=> miss_count_o == $past(miss_count_o) + 1'b1);

  // R9
  count_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (miss_count_o == CMAX) |=> miss_count_o == CMAX);

endmodule

bind bfc_flush_ctrl bfc_flush_ctrl_chk #(.AW(AW), .STEP(STEP), .CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .stall_i        (stall_i),
  .ex_br_valid_i  (ex_br_valid_i),
  .ex_br_taken_i  (ex_br_taken_i),
  .ex_br_target_i (ex_br_target_i),
  .fetch_pc_o     (fetch_pc_o),
  .pc_next_o      (pc_next_o),
  .flush_ifid_o   (flush_ifid_o),
  .flush_idex_o   (flush_idex_o),
  .ifid_valid_o   (ifid_valid_o),
  .idex_valid_o   (idex_valid_o),
  .miss_count_o   (miss_count_o)
);

// File: tb/bfc_flush_ctrl_test.sv
`timescale 1ns/1ps
module bfc_flush_ctrl_test;

  localparam int AW    = 32;
  localparam int CNT_W = 3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             stall_i = 1'b0;
  logic             ex_br_valid_i = 1'b0;
  logic             ex_br_taken_i = 1'b0;
  logic [AW-1:0]    ex_br_target_i = '0;
  logic [AW-1:0]    fetch_pc_o;
  logic [AW-1:0]    pc_next_o;
  logic             flush_ifid_o;
  logic             flush_idex_o;
  logic             ifid_valid_o;
  logic             idex_valid_o;
  logic [CNT_W-1:0] miss_count_o;

  always #2 clk = ~clk;

  bfc_flush_ctrl #(.AW(AW), .STEP(4), .CNT_W(CNT_W)) uut (
    .clk            (clk),
    .rst            (rst),
    .stall_i        (stall_i),
    .ex_br_valid_i  (ex_br_valid_i),
    .ex_br_taken_i  (ex_br_taken_i),
    .ex_br_target_i (ex_br_target_i),
    .fetch_pc_o     (fetch_pc_o),
    .pc_next_o      (pc_next_o),
    .flush_ifid_o   (flush_ifid_o),
    .flush_idex_o   (flush_idex_o),
    .ifid_valid_o   (ifid_valid_o),
    .idex_valid_o   (idex_valid_o),
    .miss_count_o   (miss_count_o)
  );

  typedef struct {
    string         tag;
    logic          flush;
    logic [AW-1:0] nxt;
    logic [AW-1:0] pc;
    logic          ifid;
    logic          idex;
    logic [31:0]   cnt;
  } exp_t;

  exp_t q[$];
  int   tests = 0;
  int   fails = 0;
  bit   done  = 1'b0;

  logic [AW-1:0] m_pc   = '0;
  logic          m_ifid = 1'b0;
  logic          m_idex = 1'b0;
  int            m_cnt  = 0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Driver: drive one cycle of stimulus and queue what the model predicts.
  task automatic step(input logic r, input logic s, input logic bv,
                      input logic bt, input logic [AW-1:0] tg, input string tag);
    exp_t e;
    logic tk;
    @(negedge clk);
    rst = r; stall_i = s; ex_br_valid_i = bv; ex_br_taken_i = bt; ex_br_target_i = tg;
    tk      = bv & bt & m_idex & ~r;
    e.tag   = tag;
    e.flush = tk;
    if (r) begin
      e.nxt = 'x;
      m_pc = '0; m_ifid = 1'b0; m_idex = 1'b0; m_cnt = 0;
    end else if (tk) begin
      e.nxt = tg;
      m_pc = tg; m_ifid = 1'b0; m_idex = 1'b0;
      if (m_cnt < (1 << CNT_W) - 1) m_cnt++;
    end else if (s) begin
      e.nxt = m_pc;
      m_idex = 1'b0;
    end else begin
      m_pc = m_pc + 4;
      e.nxt = m_pc;
      m_idex = m_ifid; m_ifid = 1'b1;
    end
    e.pc = m_pc; e.ifid = m_ifid; e.idex = m_idex; e.cnt = m_cnt;
    q.push_back(e);
  endtask

  // Monitor: same-cycle outputs after the drive, registered ones after the edge.
  initial begin
    logic          c_fi, c_fx;
    logic [AW-1:0] c_nxt;
    exp_t          e;
    forever begin
      @(negedge clk);
      #1;
      c_fi = flush_ifid_o; c_fx = flush_idex_o; c_nxt = pc_next_o;
      @(posedge clk);
      #1;
      if (q.size() != 0) begin
        e = q.pop_front();
        if (!rst) begin
          chk(e.tag, "flush_ifid", 32'(c_fi), 32'(e.flush));
          chk(e.tag, "flush_idex", 32'(c_fx), 32'(e.flush));
          chk(e.tag, "pc_next", c_nxt, e.nxt);
        end
        chk(e.tag, "fetch_pc", fetch_pc_o, e.pc);
        chk(e.tag, "ifid_valid", 32'(ifid_valid_o), 32'(e.ifid));
        chk(e.tag, "idex_valid", 32'(idex_valid_o), 32'(e.idex));
        chk(e.tag, "miss_count", 32'(miss_count_o), e.cnt);
      end
    end
  end

  initial begin
    #20000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    step(1, 0, 0, 0, '0, "R1");
    step(1, 0, 0, 0, '0, "R1");
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, '0, "R2");
    step(0, 0, 1, 0, 32'h0000_0800, "R5");
    step(0, 0, 0, 0, '0, "R5");
    step(0, 0, 1, 1, 32'h0000_0100, "R3");
    step(0, 0, 1, 1, 32'h0000_0040, "R8");
    step(0, 0, 0, 0, '0, "R4");
    step(0, 0, 0, 0, '0, "R2");
    step(0, 1, 0, 0, '0, "R6");
    step(0, 1, 0, 0, '0, "R6");
    step(0, 0, 0, 0, '0, "R2");
    step(0, 0, 0, 0, '0, "R2");
    step(0, 1, 1, 1, 32'h0000_0200, "R7");
    step(0, 0, 0, 0, '0, "R4");
    step(0, 0, 0, 0, '0, "R2");
    for (int i = 0; i < 9; i++) begin
      step(0, 0, 1, 1, AW'(32'h1000 + i * 32'h40), "R9");
      step(0, 0, 0, 0, '0, "R9");
      step(0, 0, 0, 0, '0, "R9");
    end
    step(0, 0, 1, 0, 32'h0000_0300, "R5");
    step(0, 0, 0, 0, '0, "R2");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule